// File: doc/BRIEF.md
# Cascadable Presettable Binary Counter

This block is a small synchronous up counter, four bits wide by default, that can be preset from a data input and that counts only when two separate enables are both high. One enable (`cnt_en`) gates counting alone. The other (`chain_en`) gates counting and also qualifies the terminal-count flag. Several stages can therefore be chained: every stage after the first takes the previous stage's flag as its `chain_en`. All stages share one clock and one `cnt_en`, and together they form a wider counter that still advances in a single clock edge.

A parameter chooses how the active-low clear works. In one variant the clear resets the register at once, with no clock edge. In the other it resets the register on the next rising edge and takes priority over the load. The synchronous variant can shorten its own counting cycle when a decode of one chosen count value drives the clear input.

Top module: `casc_bin_counter`

## Requirements
- R1: Every bit of `q` changes on the same rising edge of `clk`, and a loaded `WIDTH`-bit value appears whole one edge after it is applied.
- R2: With `clr_n` high and `load_n` low, the next rising edge puts `d_in` into `q`, whatever the levels of `cnt_en` and `chain_en`.
- R3: With `clr_n` and `load_n` high and both enables high, each rising edge adds one to `q`. After all ones the count wraps to zero.
- R4: With `clr_n` and `load_n` high and either enable low, `q` keeps its value across the edge.
- R5: With `ASYNC_CLR`=1, a low `clr_n` forces `q` to zero immediately, with no clock edge, and holds it at zero while it stays low.
- R6: With `ASYNC_CLR`=0, a low `clr_n` leaves `q` unchanged until the next rising edge. At that edge it sets `q` to zero, ahead of the load and both enables.
- R7: `tc` is high exactly when `chain_en` is high, `clr_n` is high and `q` is all ones. `load_n` and `cnt_en` have no effect on it.
- R8: `tc` is low whenever `clr_n` is low.
- R9: Stages chained through `tc` into the next `chain_en`, sharing `cnt_en`, count as one wide synchronous binary counter, including carries across every stage boundary and the full wrap.
- R10: With `ASYNC_CLR`=0, driving `clr_n` low while `q` equals 6 makes the counter step through 0 to 6 and then return to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear; asynchronous or synchronous per `ASYNC_CLR` |
| load_n | input | 1 | Active-low parallel load |
| cnt_en | input | 1 | Count enable that gates counting only |
| chain_en | input | 1 | Count enable that also qualifies `tc` |
| d_in | input | WIDTH | Preset value |
| q | output | WIDTH | Current count |
| tc | output | 1 | Terminal-count flag |

## Verification
Almost every fault in the next-value or priority logic shows at `q` on the first rising edge after the input combination that exposes it. The exception is a clear that acts too early in the synchronous variant, which shows before any edge. The bench therefore compares `q` after every edge, and also between edges while a new control pattern is held. An error in the terminal-count path shows at `tc` in the same cycle as the pattern that causes it. In a chain, the same error appears as a missing or extra carry into the next stage on the following edge. Carry faults are therefore found within one cycle of a stage reaching all ones.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  // Operation chosen for the next clock edge, highest priority last
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_COUNT = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } ctr_op_e;

  // Next register value for a given operation; operands are zero-extended
  // to 32 bits by the caller, which keeps WIDTH <= 32
  function automatic logic [31:0] ctr_next(ctr_op_e op, logic [31:0] cur,
                                           logic [31:0] ld);
    case (op)
      OP_CLEAR: ctr_next = '0;
      OP_LOAD:  ctr_next = ld;
      OP_COUNT: ctr_next = cur + 32'd1;
      default:  ctr_next = cur;
    endcase
  endfunction

  // True when the low `width` bits of v are all ones
  function automatic logic ctr_is_max(logic [31:0] v, int unsigned width);
    logic [31:0] mask;
    mask = (width >= 32) ? 32'hFFFF_FFFF : ((32'd1 << width) - 32'd1);
    ctr_is_max = ((v & mask) == mask);
  endfunction

endpackage

// File: rtl/ctr_op_decode.sv
module ctr_op_decode
  import ctr_pkg::*;
(
  input  logic    clr_n,
  input  logic    load_n,
  input  logic    cnt_en,
  input  logic    chain_en,
  output ctr_op_e op
);

  // Priority: clear, then load, then count, otherwise hold
  always_comb begin
    if (!clr_n)                   op = OP_CLEAR;
    else if (!load_n)             op = OP_LOAD;
    else if (cnt_en && chain_en)  op = OP_COUNT;
    else                          op = OP_HOLD;
  end

endmodule

// File: rtl/ctr_state.sv
module ctr_state
  import ctr_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  ctr_op_e          op,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] q_r;
  logic [WIDTH-1:0] q_nxt;

  always_comb q_nxt = WIDTH'(ctr_next(op, 32'(q_r), 32'(d_in)));

  generate
    if (ASYNC_CLR) begin : g_async_clr
      always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) q_r <= '0;
        else        q_r <= q_nxt;
      end
    end else begin : g_sync_clr
      // OP_CLEAR already yields zero through the next-value function
      always_ff @(posedge clk) begin
        q_r <= q_nxt;
      end
    end
  endgenerate

  assign q = q_r;

endmodule

// File: rtl/ctr_tc.sv
module ctr_tc
  import ctr_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q,
  input  logic             chain_en,
  input  logic             clr_n,
  output logic             at_max,
  output logic             tc
);

  assign at_max = ctr_is_max(32'(q), WIDTH);
  // Gated by clr_n so the synchronous variant shows no flag during a clear
  assign tc     = at_max & chain_en & clr_n;

endmodule

// File: rtl/casc_bin_counter.sv
module casc_bin_counter
  import ctr_pkg::*;
#(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input  logic             clk,
  input  logic             clr_n,
  input  logic             load_n,
  input  logic             cnt_en,
  input  logic             chain_en,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] q,
  output logic             tc
);

  ctr_op_e op;

  // Named events for the bound checker
  logic ev_clear;
  logic ev_load;
  logic ev_count;
  logic at_max;

  ctr_op_decode u_dec (
    .clr_n    (clr_n),
    .load_n   (load_n),
    .cnt_en   (cnt_en),
    .chain_en (chain_en),
    .op       (op)
  );

  assign ev_clear = (op == OP_CLEAR);
  assign ev_load  = (op == OP_LOAD);
  assign ev_count = (op == OP_COUNT);

  ctr_state #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_state (
    .clk   (clk),
    .clr_n (clr_n),
    .op    (op),
    .d_in  (d_in),
    .q     (q)
  );

  ctr_tc #(.WIDTH(WIDTH)) u_tc (
    .q        (q),
    .chain_en (chain_en),
    .clr_n    (clr_n),
    .at_max   (at_max),
    .tc       (tc)
  );

endmodule

// File: rtl/ctr_checker.sv
module ctr_checker #(
  parameter int WIDTH     = 4,
  parameter bit ASYNC_CLR = 1'b1
) (
  input logic             clk,
  input logic             clr_n,
  input logic             load_n,
  input logic             cnt_en,
  input logic             chain_en,
  input logic [WIDTH-1:0] d_in,
  input logic [WIDTH-1:0] q,
  input logic             tc,
  input logic             ev_clear,
  input logic             ev_load,
  input logic             ev_count,
  input logic             at_max
);

  logic started = 1'b0;
  always_ff @(posedge clk) started <= 1'b1;

  // R2: a load puts the data into the register on the next edge
  a_r2_load_takes_data: assert property (@(posedge clk) disable iff (!clr_n)
    (started && ev_load) |=> (q == $past(d_in)));

  // R3: a count step adds one, modulo 2**WIDTH
  a_r3_count_step: assert property (@(posedge clk) disable iff (!clr_n)
    (started && ev_count) |=> (q == WIDTH'($past(q) + 1'b1)));

  // R4: either enable low with no load keeps the value
  a_r4_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (started && load_n && !(cnt_en && chain_en)) |=> $stable(q));

  // R7: the flag never rises away from the all-ones count with chain_en high
  a_r7_tc_needs_max: assert property (@(posedge clk) disable iff (!started)
    tc |-> (at_max && chain_en));

  // R7: all ones with chain_en and no clear always raises the flag
  a_r7_tc_when_max: assert property (@(posedge clk) disable iff (!started)
    (at_max && chain_en && clr_n) |-> tc);

  // R8: no flag while the clear is held
  a_r8_tc_low_in_clear: assert property (@(posedge clk) disable iff (!started)
    (!clr_n) |-> !tc);

  generate
    if (ASYNC_CLR) begin : g_chk_async
      // R5: register already zero at any edge seen with the clear low
      a_r5_async_zero: assert property (@(posedge clk) disable iff (!started)
        (!clr_n) |-> (q == '0));
    end else begin : g_chk_sync
      // R6: a synchronous clear yields zero after the edge
      a_r6_sync_zero: assert property (@(posedge clk) disable iff (!started)
        ev_clear |=> (q == '0));
    end
  endgenerate

endmodule

bind casc_bin_counter ctr_checker #(.WIDTH(WIDTH), .ASYNC_CLR(ASYNC_CLR)) u_chk (.*);

// File: tb/casc_bin_counter_test.sv
module casc_bin_counter_test;

  localparam int CLK_P = 10;
  localparam int W     = 4;
  localparam int NST   = 3;
  localparam int CW    = W * NST;

  logic clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // Shared stimulus for the single-stage pair
  logic         clr_n    = 1'b1;
  logic         load_n   = 1'b1;
  logic         cnt_en   = 1'b0;
  logic         chain_en = 1'b0;
  logic [W-1:0] d_in     = '0;
  logic         mod_on   = 1'b0;

  logic [W-1:0] qa, qs;
  logic         tca, tcs;
  logic         s_clr_n;

  assign s_clr_n = mod_on ? (qs != W'(6)) : clr_n;

  casc_bin_counter #(.WIDTH(W), .ASYNC_CLR(1'b1)) uut (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .cnt_en(cnt_en),
    .chain_en(chain_en), .d_in(d_in), .q(qa), .tc(tca));

  casc_bin_counter #(.WIDTH(W), .ASYNC_CLR(1'b0)) uut_s (
    .clk(clk), .clr_n(s_clr_n), .load_n(load_n), .cnt_en(cnt_en),
    .chain_en(chain_en), .d_in(d_in), .q(qs), .tc(tcs));

  // Chain of synchronous-clear stages
  logic          ch_clr_n = 1'b1;
  logic          ch_ld_n  = 1'b1;
  logic          ch_en    = 1'b0;
  logic [CW-1:0] ch_din   = '0;
  logic [CW-1:0] ch_q;
  logic [NST-1:0] ch_tc;
  logic [NST-1:0] ch_et;

  for (genvar k = 0; k < NST; k++) begin : g_chain
    if (k == 0) begin : g_first
      assign ch_et[k] = ch_en;
    end else begin : g_next
      assign ch_et[k] = ch_tc[k-1];
    end
    casc_bin_counter #(.WIDTH(W), .ASYNC_CLR(1'b0)) u_stage (
      .clk(clk), .clr_n(ch_clr_n), .load_n(ch_ld_n), .cnt_en(ch_en),
      .chain_en(ch_et[k]), .d_in(ch_din[k*W +: W]), .q(ch_q[k*W +: W]),
      .tc(ch_tc[k]));
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int nxt(int cur, logic c, logic l, logic p, logic t, int d);
    if (!c) return 0;
    if (!l) return d;
    if (p && t) return (cur + 1) % 16;
    return cur;
  endfunction

  function automatic logic exp_tc(int cur, logic c, logic t);
    return c && t && (cur == 15);
  endfunction

  function automatic string tag(logic c, logic l, logic p, logic t, bit async_v);
    if (!c) return async_v ? "R5" : "R6";
    if (!l) return "R2";
    if (p && t) return "R3";
    return "R4";
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  int ma, ms;
  logic [CW-1:0] cm;

  initial begin
    // Reset: clears go low between edges
    #2;
    clr_n = 1'b0;
    ch_clr_n = 1'b0;
    #1;
    chk("R5 async clear without edge", 32'(qa), 0);
    chk("R8 tc low in clear", 32'(tca), 0);
    @(posedge clk); @(negedge clk);
    chk("R6 sync clear at edge", 32'(qs), 0);
    chk("R8 tc low in sync clear", 32'(tcs), 0);
    chk("R6 chain cleared", 32'(ch_q), 0);
    ma = 0; ms = 0; cm = '0;
    clr_n = 1'b1;
    ch_clr_n = 1'b1;

    // Exhaustive sweep: every start value times every control pattern
    for (int s = 0; s < 16; s++) begin
      for (int c = 0; c < 16; c++) begin
        clr_n = 1'b1; load_n = 1'b0; cnt_en = c[1]; chain_en = c[0];
        d_in = W'(s);
        @(posedge clk);
        ma = s; ms = s;
        @(negedge clk);
        chk("R1 whole value loaded (async)", 32'(qa), 32'(ma));
        chk("R1 whole value loaded (sync)", 32'(qs), 32'(ms));

        clr_n = c[3]; load_n = c[2]; cnt_en = c[1]; chain_en = c[0];
        d_in = W'(15 - s);
        #1;
        if (!clr_n) ma = 0;
        chk(clr_n ? "R4 between edges (async)" : "R5 immediate clear", 32'(qa), 32'(ma));
        chk(clr_n ? "R4 between edges (sync)" : "R6 no clear before edge", 32'(qs), 32'(ms));
        chk(clr_n ? "R7 tc (async)" : "R8 tc (async)", 32'(tca), 32'(exp_tc(ma, clr_n, chain_en)));
        chk(clr_n ? "R7 tc (sync)" : "R8 tc (sync)", 32'(tcs), 32'(exp_tc(ms, clr_n, chain_en)));
        @(posedge clk);
        ma = nxt(ma, clr_n, load_n, cnt_en, chain_en, 15 - s);
        ms = nxt(ms, clr_n, load_n, cnt_en, chain_en, 15 - s);
        @(negedge clk);
        chk(tag(clr_n, load_n, cnt_en, chain_en, 1'b1), 32'(qa), 32'(ma));
        chk(tag(clr_n, load_n, cnt_en, chain_en, 1'b0), 32'(qs), 32'(ms));
        chk("R7 tc after edge (async)", 32'(tca), 32'(exp_tc(ma, clr_n, chain_en)));
        chk("R7 tc after edge (sync)", 32'(tcs), 32'(exp_tc(ms, clr_n, chain_en)));
      end
    end

    // Modulo-7 cycle through decode feedback on the synchronous variant
    clr_n = 1'b1; load_n = 1'b0; cnt_en = 1'b0; chain_en = 1'b0; d_in = '0;
    @(posedge clk); ms = 0; @(negedge clk);
    load_n = 1'b1; cnt_en = 1'b1; chain_en = 1'b1; mod_on = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(posedge clk);
      ms = (ms == 6) ? 0 : ms + 1;
      @(negedge clk);
      chk("R10 shortened cycle", 32'(qs), 32'(ms));
    end
    mod_on = 1'b0; cnt_en = 1'b0; chain_en = 1'b0;

    // Chain: load near the top, count through the full wrap
    ch_ld_n = 1'b0; ch_din = CW'(12'hFF0); ch_en = 1'b0;
    @(posedge clk); cm = CW'(12'hFF0); @(negedge clk);
    chk("R9 chain load", 32'(ch_q), 32'(cm));
    ch_ld_n = 1'b1; ch_en = 1'b1;
    for (int i = 0; i < 40; i++) begin
      chk("R7 chain top flag", 32'(ch_tc[NST-1]), 32'(cm == '1));
      @(posedge clk);
      cm = cm + 1'b1;
      @(negedge clk);
      for (int k = 0; k < NST; k++)
        chk("R9 chain stage", 32'(ch_q[k*W +: W]), 32'(cm[k*W +: W]));
    end
    ch_en = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); @(negedge clk);
      chk("R4 chain hold", 32'(ch_q), 32'(cm));
    end

    // Chain: carry from stage 0 into stage 1 and stage 2
    ch_ld_n = 1'b0; ch_din = CW'(12'h0FC);
    @(posedge clk); cm = CW'(12'h0FC); @(negedge clk);
    ch_ld_n = 1'b1; ch_en = 1'b1;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk);
      cm = cm + 1'b1;
      @(negedge clk);
      for (int k = 0; k < NST; k++)
        chk("R9 chain carry", 32'(ch_q[k*W +: W]), 32'(cm[k*W +: W]));
    end
    ch_en = 1'b0;

    finish_run();
  end

endmodule